// File: doc/BRIEF.md
# Dual-Unit Page Validity Filter

This block sits on the playback path behind a page-organised store. Every page read delivers two transfer units back to back, the high unit first and the low unit second, together with a small sideband tag that says what each unit is: the head, a body unit or the tail of an image on the extracted channel, or something else (another channel or unrelated data). The filter works out a keep flag for each half of every page and writes only the kept units into an output buffer. The units it drops are discarded without a trace, so the output byte stream holds only the bytes of the image being extracted.

The filter tracks whether an image is open. A head opens it, a kept tail closes it, and body or tail units are only kept while an image is open. When a page carries a tail followed by the head of the next image, the tail is kept and that head is dropped. The output is a valid/ready byte stream whose last-flag marks the final byte of the image. The page input is paced by a ready signal that only falls at the start of a unit that is to be kept and does not fit in the buffer.

Top module: `page_validity_filter`

## Requirements
- R1: After synchronous reset `out_valid` is 0, `in_ready` is 1, no image is open, and body or tail units arriving before any head are dropped.
- R2: `in_tag[3:2]` gives the kind of the high unit and `in_tag[1:0]` the kind of the low unit, sampled with the byte marked by `in_sop`; kinds are 0 = other, 1 = head, 2 = body, 3 = tail. A head is kept (except as in R4) and opens an image; a body or tail is kept only while an image is open; an "other" unit is never kept.
- R3: Every kept unit reaches the output complete and in arrival order, the high unit before the low unit of the same page; dropped units contribute no bytes.
- R4: A page holding a kept tail in the high half and a head in the low half keeps the tail, closes the image and drops the head.
- R5: When an image unit shares a page with an "other" unit, in either half, only the image unit is kept.
- R6: A page holding a head followed by a body keeps both units.
- R7: `out_last` is 1 on the final byte of a kept tail unit and 0 on every other output byte.
- R8: `in_ready` is 0 only on the first byte of a kept unit while fewer than `UNIT_BYTES` bytes of buffer space are free; it is 1 on every byte inside a unit, and the buffer never overflows.
- R9: A page whose two units are both dropped is accepted at one byte per cycle with `in_ready` held at 1, even with a full buffer, and produces no output.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Page byte present |
| in_ready | output | 1 | Filter accepts the page byte this cycle |
| in_data | input | 8 | Page byte |
| in_sop | input | 1 | Marks the first byte of a page |
| in_tag | input | 4 | Unit kinds of the page, sampled with `in_sop` |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte of the extracted image |
| out_last | output | 1 | Final byte of the image |

## Verification
The bench runs a small configuration with four-byte units and sends every ordered pair of the sixteen page tags, so each tag is seen both with an image open and with it closed. That separates a filter that judges each unit by its own kind alone from one that tracks the open image, and it tells whether a dropped head behind a tail is handled apart from a head that starts a new image. Directed sequences cover the head page, the tail-then-head page and mixing with foreign units, and a filled buffer with the output stalled shows whether back-pressure is limited to unit starts and whether fully dropped pages still pass without a stall.

// File: rtl/pvf_pkg.sv
package pvf_pkg;

    typedef enum logic [1:0] {
        UK_OTHER = 2'd0,
        UK_HEAD  = 2'd1,
        UK_BODY  = 2'd2,
        UK_TAIL  = 2'd3
    } unit_kind_e;

    typedef struct packed {
        unit_kind_e hi;
        unit_kind_e lo;
    } page_tag_t;

    typedef struct packed {
        logic keep_hi;
        logic keep_lo;
        logic tail_hi;
        logic tail_lo;
        logic open_next;
    } page_verdict_t;

    // Keep decisions for both halves of one page, given the image-open state.
    function automatic page_verdict_t judge_page(input logic open_now, input page_tag_t tag);
        page_verdict_t v;
        logic open_mid;
        logic shut;
        v        = '0;
        open_mid = open_now;
        shut     = 1'b0;
        case (tag.hi)
            UK_HEAD: begin
                v.keep_hi = 1'b1;
                open_mid  = 1'b1;
            end
            UK_BODY: v.keep_hi = open_now;
            UK_TAIL: begin
                v.keep_hi = open_now;
                v.tail_hi = open_now;
                if (open_now) begin
                    open_mid = 1'b0;
                    shut     = 1'b1;
                end
            end
            default: ;
        endcase
        v.open_next = open_mid;
        case (tag.lo)
            UK_HEAD: begin
                v.keep_lo = !shut;
                if (!shut) v.open_next = 1'b1;
            end
            UK_BODY: v.keep_lo = open_mid;
            UK_TAIL: begin
                v.keep_lo = open_mid;
                v.tail_lo = open_mid;
                if (open_mid) v.open_next = 1'b0;
            end
            default: ;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pvf_tag_decoder.sv
module pvf_tag_decoder
    import pvf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          sop,
    input  logic          accept,
    input  page_tag_t     tag,
    output page_verdict_t verdict
);
    logic          open_q;
    page_verdict_t held_q;
    page_verdict_t fresh;

    always_comb begin
        fresh   = judge_page(open_q, tag);
        verdict = sop ? fresh : held_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            held_q <= '0;
        end else if (accept && sop) begin
            open_q <= fresh.open_next;
            held_q <= fresh;
        end
    end
endmodule

// File: rtl/pvf_page_cursor.sv
module pvf_page_cursor #(
    parameter int UNIT_BYTES = 1024,
    localparam int PAGE_BYTES = 2 * UNIT_BYTES,
    localparam int IDX_W      = $clog2(PAGE_BYTES)
) (
    input  logic clk,
    input  logic rst,
    input  logic sop,
    input  logic step,
    output logic hi_half,
    output logic unit_first,
    output logic unit_final
);
    localparam logic [IDX_W-1:0] IDX_MID  = IDX_W'(UNIT_BYTES);
    localparam logic [IDX_W-1:0] IDX_HEND = IDX_W'(UNIT_BYTES - 1);
    localparam logic [IDX_W-1:0] IDX_PEND = IDX_W'(PAGE_BYTES - 1);

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_cur;

    always_comb begin
        idx_cur    = sop ? '0 : idx_q;
        hi_half    = idx_cur < IDX_MID;
        unit_first = (idx_cur == '0) || (idx_cur == IDX_MID);
        unit_final = (idx_cur == IDX_HEND) || (idx_cur == IDX_PEND);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (step) begin
            idx_q <= (idx_cur == IDX_PEND) ? '0 : idx_cur + 1'b1;
        end
    end
endmodule

// File: rtl/pvf_byte_fifo.sv
module pvf_byte_fifo #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 9,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             not_empty,
    output logic [CNT_W-1:0] count
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    assign rd_data   = mem[rd_ptr];
    assign not_empty = (count != '0);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (rd_en) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/page_validity_filter.sv
module page_validity_filter
    import pvf_pkg::*;
#(
    parameter int UNIT_BYTES = 1024,
    parameter int BUF_UNITS  = 2,
    localparam int DEPTH = BUF_UNITS * UNIT_BYTES,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [7:0] in_data,
    input  logic       in_sop,
    input  logic [3:0] in_tag,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_data,
    output logic       out_last
);
    localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] UNIT = CNT_W'(UNIT_BYTES);

    page_verdict_t    verdict;
    logic             hi_half;
    logic             unit_first;
    logic             unit_final;
    logic             cur_keep;
    logic             cur_tail;
    logic             accept;
    logic             wr_en;
    logic             rd_en;
    logic             room;
    logic [CNT_W-1:0] fifo_count;
    logic [8:0]       rd_word;

    pvf_tag_decoder u_dec (
        .clk     (clk),
        .rst     (rst),
        .sop     (in_sop),
        .accept  (accept),
        .tag     (page_tag_t'(in_tag)),
        .verdict (verdict)
    );

    pvf_page_cursor #(.UNIT_BYTES(UNIT_BYTES)) u_cur (
        .clk        (clk),
        .rst        (rst),
        .sop        (in_sop),
        .step       (accept),
        .hi_half    (hi_half),
        .unit_first (unit_first),
        .unit_final (unit_final)
    );

    always_comb begin
        cur_keep = hi_half ? verdict.keep_hi : verdict.keep_lo;
        cur_tail = hi_half ? verdict.tail_hi : verdict.tail_lo;
        room     = (CAP - fifo_count) >= UNIT;
        // Space for a whole kept unit is reserved at its first byte.
        in_ready = !(unit_first && cur_keep) || room;
        accept   = in_valid && in_ready;
        wr_en    = accept && cur_keep;
        rd_en    = out_valid && out_ready;
    end

    pvf_byte_fifo #(.DEPTH(DEPTH), .WIDTH(9)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   ({cur_tail && unit_final, in_data}),
        .rd_en     (rd_en),
        .rd_data   (rd_word),
        .not_empty (out_valid),
        .count     (fifo_count)
    );

    assign out_data = rd_word[7:0];
    assign out_last = rd_word[8];
endmodule

// File: rtl/pvf_checker.sv
module pvf_checker #(
    parameter int DEPTH = 2048,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             cur_keep,
    input logic             unit_first,
    input logic             wr_en,
    input logic [CNT_W-1:0] fifo_count
);
    // R1: buffer comes out of reset empty
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);

    // R8: inside a unit the input is never held off
    a_r8_mid_unit_ready: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !unit_first) |-> in_ready);

    // R8: no write lands in a full buffer
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (fifo_count < CNT_W'(DEPTH)));

    // R9: a dropped unit never stalls the input
    a_r9_drop_no_stall: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !cur_keep) |-> in_ready);

    // R10: stalled output holds
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind page_validity_filter pvf_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_page_validity_filter.sv
module tb_page_validity_filter;
    localparam int CLK_PERIOD = 10;
    localparam int UB = 4;
    localparam int BU = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = '0;
    logic       in_sop = 1'b0;
    logic [3:0] in_tag = '0;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [7:0] out_data;
    logic       out_last;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int rdy_mode = 0;
    int rx_bytes = 0;
    int rx_lasts = 0;
    int mid_stalls = 0;
    int first_stalls = 0;
    int page_stalls = 0;
    logic [7:0] dcnt = '0;
    logic m_open = 1'b0;
    logic [8:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    page_validity_filter #(.UNIT_BYTES(UB), .BUF_UNITS(BU)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_sop(in_sop), .in_tag(in_tag),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .out_last(out_last)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Requirement model: kinds 0 other, 1 head, 2 body, 3 tail (R2, R4, R5, R6).
    task automatic model_page(input logic [1:0] hk, input logic [1:0] lk,
                              output logic kh, output logic kl, output logic th, output logic tl);
        logic tail_seen;
        tail_seen = 1'b0;
        kh = (hk == 2'd1) || ((hk == 2'd2 || hk == 2'd3) && m_open);
        th = (hk == 2'd3) && kh;
        if (hk == 2'd1) m_open = 1'b1;
        if (th) begin m_open = 1'b0; tail_seen = 1'b1; end
        kl = (lk == 2'd1) ? !tail_seen : ((lk == 2'd2 || lk == 2'd3) && m_open);
        tl = (lk == 2'd3) && kl;
        if (lk == 2'd1 && kl) m_open = 1'b1;
        if (tl) m_open = 1'b0;
    endtask

    task automatic send_page(input logic [1:0] hk, input logic [1:0] lk);
        logic kh, kl, th, tl, k, t;
        model_page(hk, lk, kh, kl, th, tl);
        page_stalls = 0;
        for (int i = 0; i < 2*UB; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_tag   = {hk, lk};
            in_data  = dcnt;
            #(CLK_PERIOD/4);
            while (!in_ready) begin
                page_stalls++;
                if (i == 0 || i == UB) first_stalls++;
                else mid_stalls++;
                @(negedge clk);
                #(CLK_PERIOD/4);
            end
            @(posedge clk);
            k = (i < UB) ? kh : kl;
            t = (i < UB) ? th : tl;
            if (k) exp_q.push_back({t && (i == UB-1 || i == 2*UB-1), dcnt});
            dcnt = dcnt + 8'd1;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sop   = 1'b0;
    endtask

    task automatic drain();
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
    endtask

    // Output side: drives out_ready and checks every popped byte (R3, R7).
    initial begin
        forever begin
            @(negedge clk);
            case (rdy_mode)
                0: out_ready = 1'b1;
                1: out_ready = cycles[0] ^ cycles[2];
                default: out_ready = 1'b0;
            endcase
            #1;
            if (out_valid && out_ready) begin
                rx_bytes++;
                if (out_last) rx_lasts++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected output byte", out_data, -1);
                end else begin
                    check(out_data == exp_q[0][7:0], "R3 output data", out_data, exp_q[0][7:0]);
                    check(out_last == exp_q[0][8], "R7 output last flag", out_last, exp_q[0][8]);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                check(1'b0, "watchdog expired", cycles, 150000);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        int b0, l0;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #(CLK_PERIOD/4);
        check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);

        // R1: body and tail before any head are dropped
        b0 = rx_bytes;
        send_page(2'd2, 2'd3);
        drain();
        check(rx_bytes == b0, "R1 no output before a head", rx_bytes - b0, 0);

        // R6: head page keeps head and body
        b0 = rx_bytes;
        send_page(2'd1, 2'd2);
        drain();
        check(rx_bytes - b0 == 2*UB, "R6 head plus body kept", rx_bytes - b0, 2*UB);

        // R4: tail then next head
        b0 = rx_bytes; l0 = rx_lasts;
        send_page(2'd3, 2'd1);
        drain();
        check(rx_bytes - b0 == UB, "R4 tail kept, next head dropped", rx_bytes - b0, UB);
        check(rx_lasts - l0 == 1, "R7 one last flag per image", rx_lasts - l0, 1);

        // R2: image now closed, body/tail dropped
        b0 = rx_bytes;
        send_page(2'd2, 2'd2);
        drain();
        check(rx_bytes == b0, "R2 body dropped while closed", rx_bytes - b0, 0);

        // R5: mixing with foreign units
        b0 = rx_bytes; l0 = rx_lasts;
        send_page(2'd1, 2'd0);
        send_page(2'd0, 2'd2);
        send_page(2'd3, 2'd0);
        drain();
        check(rx_bytes - b0 == 3*UB, "R5 only image units kept", rx_bytes - b0, 3*UB);
        check(rx_lasts - l0 == 1, "R7 tail beside foreign unit", rx_lasts - l0, 1);

        // R8/R9/R10: full buffer with output stalled
        rdy_mode = 2;
        @(negedge clk);
        send_page(2'd1, 2'd2);
        check(page_stalls == 0, "R8 two units fit in empty buffer", page_stalls, 0);
        b0 = rx_bytes;
        send_page(2'd0, 2'd0);
        check(page_stalls == 0, "R9 dropped page never stalls", page_stalls, 0);
        check(rx_bytes == b0, "R9 dropped page adds nothing", rx_bytes - b0, 0);
        #(CLK_PERIOD/4);
        held = out_data;
        repeat (4) @(negedge clk);
        #(CLK_PERIOD/4);
        check(out_valid && out_data == held, "R10 stalled output holds", out_data, held);
        fork
            send_page(2'd2, 2'd3);
            begin
                repeat (5) @(negedge clk);
                #(CLK_PERIOD/4);
                check(in_valid && !in_ready, "R8 kept unit held off when full", in_ready, 0);
                rdy_mode = 0;
            end
        join
        check(page_stalls > 0, "R8 stall seen at unit start", page_stalls, 1);
        drain();

        // Sweep of every ordered pair of page tags
        for (int a = 0; a < 16; a++) begin
            rdy_mode = a % 2;
            for (int b = 0; b < 16; b++) begin
                send_page(a[3:2], a[1:0]);
                send_page(b[3:2], b[1:0]);
            end
        end
        rdy_mode = 0;
        drain();

        check(exp_q.size() == 0, "R3 every kept byte delivered", exp_q.size(), 0);
        check(mid_stalls == 0, "R8 no stall inside a unit", mid_stalls, 0);
        check(out_valid == 1'b0, "R3 nothing extra left", out_valid, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule